// File: doc/BRIEF.md
# Multi-source system reset controller

This block merges four independent reset requests into a single registered, active-high system reset for a low-speed clock domain (nominally 32.768 kHz). The requests are a power-on indication (the oscillator has not yet been reported running), an active-high external reset pin, a chord of key inputs all held high together, and a single-cycle watchdog overflow pulse.

The pin and the key chord are each screened by a noise rejector. This is a counter that needs an unbroken run of high samples before it passes the request, and it restarts on any low sample. Parameters choose which keys make up the chord: none, the lowest two, the lowest three, or all four. An optional second qualifier can also require the chord to persist for a much longer hold period. The output is registered and is stretched by one extra clock after the last request goes away, so even a one-cycle request yields a two-cycle reset.

Top module: `sys_reset_ctrl`

## Requirements
- R1: While `arst_n` is low, `sys_rst` is 1.
- R2: While `osc_ok` is 0, `sys_rst` is 1 from the following clock edge onward. After `osc_ok` rises with no other request, `sys_rst` is still 1 after the first edge and is 0 after the second edge.
- R3: Suppose `rst_pin` is sampled high at edges 1 to N, where N is `REJECT_CYC`. Then `sys_rst` is still 0 after edge N and is 1 after edge N+1. A high run of only N-1 samples never asserts `sys_rst`.
- R4: Once `rst_pin` is first sampled low at edge a, `sys_rst` is still 1 after edge a+1 and is 0 after edge a+2.
- R5: The key chord uses the mask 0000 for `KEY_SEL`=0, 0011 for 1, 0111 for 2 and 1111 for 3, where bit i stands for `keys[i]`. The chord is true only when the mask is nonzero and every masked key is high. Unmasked keys have no effect.
- R6: Without the hold qualifier, a chord that holds for N consecutive samples asserts `sys_rst` after edge N+1, with the same timing as R3.
- R7: With `HOLD_EN`=1, the chord must hold for N+H consecutive samples, where H is `HOLD_CYC`. `sys_rst` is 0 after edge N+H and 1 after edge N+H+1. Any low sample of a masked key restarts the whole count.
- R8: A watchdog pulse that lasts one cycle gives `sys_rst` high for exactly two cycles, starting from the next edge.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock |
| arst_n | input | 1 | Asynchronous active-low reset of the block itself |
| osc_ok | input | 1 | Oscillator reported running; 0 requests power-on reset |
| rst_pin | input | 1 | External reset pin, active high |
| keys | input | 4 | Key inputs used for the chord reset |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| sys_rst | output | 1 | Registered system reset, active high |

## Verification
Each result has a fixed edge count after its stimulus. A filtered request shows on `sys_rst` one edge after its Nth (or N+Hth) consecutive high sample. The watchdog and the oscillator indication take effect one edge after they are sampled. A release needs two more edges, because the extra stretch register adds one. The bench drives inputs on falling edges and advances one rising edge per falling edge it waits. It then samples exactly at edge N, N+1 or a+1, a+2, so it checks both the last cycle with the old value and the first cycle with the new one. Four instances with different key masks, one of them with a short hold qualifier, run through all 16 key patterns together.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  localparam int NUM_KEYS = 4;

  // Chord mask for a key selection setting: 0 none, 1 keys[1:0], 2 keys[2:0], 3 keys[3:0]
  function automatic logic [NUM_KEYS-1:0] chord_mask(input int sel);
    logic [NUM_KEYS-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (sel > 0 && i <= sel) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/rst_debounce.sv
module rst_debounce #(
  parameter int LEN = 164
) (
  input  logic clk,
  input  logic arst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    if (!din)
      cnt_d = '0;
    else if (cnt_q == LIM)
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + 1'b1;
    out_d = (cnt_d == LIM);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign dout = out_q;

  // R3
  low_drops_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !din |=> !dout);

  // R7
  rise_needs_high_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(dout) |-> $past(din));
endmodule

// File: rtl/rst_key_match.sv
module rst_key_match
  import rst_ctrl_pkg::*;
#(
  parameter int KEY_SEL = 3
) (
  input  logic [NUM_KEYS-1:0] keys,
  output logic                chord
);
  localparam logic [NUM_KEYS-1:0] MASK = chord_mask(KEY_SEL);

  generate
    if (KEY_SEL == 0) begin : g_off
      assign chord = 1'b0;
    end else begin : g_on
      assign chord = ((keys & MASK) == MASK);
    end
  endgenerate
endmodule

// File: rtl/sys_reset_ctrl.sv
module sys_reset_ctrl
  import rst_ctrl_pkg::*;
#(
  parameter int KEY_SEL    = 3,
  parameter bit HOLD_EN    = 1'b1,
  parameter int REJECT_CYC = 164,
  parameter int HOLD_CYC   = 49152
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                osc_ok,
  input  logic                rst_pin,
  input  logic [NUM_KEYS-1:0] keys,
  input  logic                wdt_ovf,
  output logic                sys_rst
);
  logic pin_flt, chord_raw, chord_flt, chord_ok;
  logic req_any;
  logic stretch_q, stretch_d;
  logic rst_q, rst_d;

  rst_debounce #(.LEN(REJECT_CYC)) u_pin_flt (
    .clk(clk), .arst_n(arst_n), .din(rst_pin), .dout(pin_flt)
  );

  rst_key_match #(.KEY_SEL(KEY_SEL)) u_match (
    .keys(keys), .chord(chord_raw)
  );

  rst_debounce #(.LEN(REJECT_CYC)) u_key_flt (
    .clk(clk), .arst_n(arst_n), .din(chord_raw), .dout(chord_flt)
  );

  generate
    if (HOLD_EN) begin : g_hold
      rst_debounce #(.LEN(HOLD_CYC)) u_hold (
        .clk(clk), .arst_n(arst_n), .din(chord_flt), .dout(chord_ok)
      );
    end else begin : g_nohold
      assign chord_ok = chord_flt;
    end
  endgenerate

  always_comb begin
    req_any   = pin_flt | chord_ok | wdt_ovf | ~osc_ok;
    stretch_d = req_any;
    rst_d     = req_any | stretch_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stretch_q <= 1'b1;
      rst_q     <= 1'b1;
    end else begin
      stretch_q <= stretch_d;
      rst_q     <= rst_d;
    end
  end

  assign sys_rst = rst_q;

  // R8
  wdt_hits_chk: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_ovf |=> sys_rst);

  // R2
  osc_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !osc_ok |=> sys_rst);

  // R4
  release_stretch_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(sys_rst) |-> ($past(osc_ok) && !$past(wdt_ovf)));
endmodule

// File: tb/sys_reset_ctrl_tb.sv
`timescale 1ns/1ps
module sys_reset_ctrl_tb;
  localparam int REJ  = 5;
  localparam int HOLD = 12;

  logic       clk;
  logic       arst_n;
  logic       osc_ok;
  logic       rst_pin;
  logic [3:0] keys;
  logic       wdt_ovf;
  logic [3:0] rst_o;

  int n_chk;
  int n_fail;
  bit done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // index 0: no chord, 1: two keys, 2: three keys with hold, 3: four keys
  sys_reset_ctrl #(.KEY_SEL(0), .HOLD_EN(1'b0), .REJECT_CYC(REJ), .HOLD_CYC(HOLD)) u_none (
    .clk(clk), .arst_n(arst_n), .osc_ok(osc_ok), .rst_pin(rst_pin),
    .keys(keys), .wdt_ovf(wdt_ovf), .sys_rst(rst_o[0]));
  sys_reset_ctrl #(.KEY_SEL(1), .HOLD_EN(1'b0), .REJECT_CYC(REJ), .HOLD_CYC(HOLD)) u_pair (
    .clk(clk), .arst_n(arst_n), .osc_ok(osc_ok), .rst_pin(rst_pin),
    .keys(keys), .wdt_ovf(wdt_ovf), .sys_rst(rst_o[1]));
  sys_reset_ctrl #(.KEY_SEL(2), .HOLD_EN(1'b1), .REJECT_CYC(REJ), .HOLD_CYC(HOLD)) u_hold (
    .clk(clk), .arst_n(arst_n), .osc_ok(osc_ok), .rst_pin(rst_pin),
    .keys(keys), .wdt_ovf(wdt_ovf), .sys_rst(rst_o[2]));
  sys_reset_ctrl #(.KEY_SEL(3), .HOLD_EN(1'b0), .REJECT_CYC(REJ), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .arst_n(arst_n), .osc_ok(osc_ok), .rst_pin(rst_pin),
    .keys(keys), .wdt_ovf(wdt_ovf), .sys_rst(rst_o[3]));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int inst, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s inst %0d: sys_rst=%b expected %b at %0t", req, inst, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req, input logic [3:0] exp);
    for (int i = 0; i < 4; i++) chk(req, i, rst_o[i], exp[i]);
  endtask

  function automatic logic [3:0] mask_of(input int sel);
    logic [3:0] m;
    m = '0;
    for (int i = 0; i < 4; i++) if (sel > 0 && i <= sel) m[i] = 1'b1;
    return m;
  endfunction

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    arst_n = 1'b0; osc_ok = 1'b0; rst_pin = 1'b0; keys = '0; wdt_ovf = 1'b0;
    tick(3);
    chk_all("R1", 4'b1111);

    // power-on source
    arst_n = 1'b1;
    tick(10);
    chk_all("R2", 4'b1111);
    osc_ok = 1'b1;
    tick(1);
    chk_all("R2", 4'b1111);
    tick(1);
    chk_all("R2", 4'b0000);
    tick(3);

    // short pin pulse is rejected
    rst_pin = 1'b1;
    tick(REJ - 1);
    rst_pin = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick(1);
      chk_all("R3", 4'b0000);
    end

    // accepted pin pulse and release timing
    rst_pin = 1'b1;
    tick(REJ);
    chk_all("R3", 4'b0000);
    tick(1);
    chk_all("R3", 4'b1111);
    tick(6);
    rst_pin = 1'b0;
    tick(2);
    chk_all("R4", 4'b1111);
    tick(1);
    chk_all("R4", 4'b0000);
    tick(3);

    // watchdog single-cycle pulse
    wdt_ovf = 1'b1;
    tick(1);
    wdt_ovf = 1'b0;
    chk_all("R8", 4'b1111);
    tick(1);
    chk_all("R8", 4'b1111);
    tick(1);
    chk_all("R8", 4'b0000);
    tick(3);

    // sweep all key patterns across the four mask settings
    for (int p = 0; p < 16; p++) begin
      logic [3:0] exp;
      for (int i = 0; i < 4; i++) begin
        exp[i] = (i != 2) && (mask_of(i) != 0) && ((4'(p) & mask_of(i)) == mask_of(i));
      end
      keys = 4'(p);
      tick(REJ);
      chk_all("R6", 4'b0000);
      tick(1);
      chk_all("R5", exp);
      chk("R7", 2, rst_o[2], 1'b0);
      keys = '0;
      tick(4);
      chk_all("R5", 4'b0000);
    end

    // hold qualifier on the three-key instance
    keys = 4'b0111;
    tick(REJ + HOLD - 2);
    keys = 4'b0101;
    tick(1);
    keys = 4'b0111;
    tick(REJ + HOLD);
    chk("R7", 2, rst_o[2], 1'b0);
    tick(1);
    chk("R7", 2, rst_o[2], 1'b1);
    keys = 4'b1111;
    tick(3);
    chk("R7", 2, rst_o[2], 1'b1);
    keys = '0;
    tick(4);
    chk_all("R7", 4'b0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule